// File: doc/BRIEF.md
# DMA Context Address Translator

This block turns a byte offset inside a DMA context into a bus address. A DMA context is a small descriptor held in memory. Its first word is a control word, its second word is the limit (the region size minus one), and page entries follow from word 2 onwards. The requester gives the word address of the descriptor, a byte offset and a direction (read or write). The block then fetches the descriptor one word at a time through a synchronous memory read port.

The block checks the offset against the limit and checks the direction against the descriptor's access code. If both pass, it fetches the one page entry that the request needs. It then returns the bus address and the target space, or a fault. The descriptor stores the base address in two parts: its low 12 bits sit in the control word as an in-page adjust, and the rest is a 4 KiB-aligned frame in the page entries.

A linear descriptor uses a single frame for the whole region. A paged descriptor holds one entry per 4 KiB page. Each result is marked by a one-cycle done pulse.

Top module: `dctx_xlate`

## Requirements
- R1: After reset, done, fault, busy and rd_en are 0, and phys_addr and target are 0.
- R2: The control word fields are: bit 13 linear, bits 15:14 access (0 read-write, 1 read-only, 2 write-only, 3 treated as read-write), bits 17:16 target space, and bits 31:20 adjust. On a translation without a fault, target equals control bits 17:16.
- R3: The limit is word 1 of the descriptor. An offset greater than the limit faults, and an offset equal to the limit does not.
- R4: In linear mode (bit 13 = 1) the page entry is at descriptor word 2. The result is phys_addr = {entry[31:12], 12'h000} + adjust + offset.
- R5: In paged mode (bit 13 = 0), eff = adjust + offset. The entry used is at descriptor word 2 + (eff >> 12), and the result is phys_addr = {entry[31:12], eff[11:0]}.
- R6: On a read-only descriptor (access 1), a write faults and a read translates.
- R7: On a write-only descriptor (access 2), a read faults and a write translates.
- R8: A write through a page entry whose bit 1 is clear faults. A read through the same entry translates.
- R9: A faulting result has phys_addr = 0 and target = 0.
- R10: Each accepted request gives exactly one single-cycle done pulse. A req_valid that arrives while busy is high is ignored.
- R11: The descriptor is read in this order: control word, limit, page entry. A fault on the limit or on the access code ends the translation after two reads, and a full translation takes three reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a translation (taken only while idle) |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_base | input | AW | Word address of the descriptor |
| req_offset | input | 32 | Byte offset inside the region |
| busy | output | 1 | Translation in progress |
| rd_en | output | 1 | Descriptor memory read strobe |
| rd_addr | output | AW | Descriptor memory word address |
| rd_data | input | 32 | Read data, valid one cycle after rd_en |
| done | output | 1 | One-cycle pulse: result valid |
| fault | output | 1 | Result is a fault |
| phys_addr | output | 32 | Translated bus address |
| target | output | 2 | Target space code of the result |

## Verification
The hardest case to reach is a paged access in which the adjust carries the offset into a later page. In that case the entry used is not the one the raw offset points to. The stimulus pairs an adjust of 0x800 with offsets such as 0x900, so the carry selects the next entry. It also gives each entry a distinct frame and write bit, so a wrong index shows up as a wrong address or a wrong fault. A second hard case is proving that a request is ignored while the block is busy. The bench pulses req_valid mid-translation with a different descriptor, then requires exactly one result and the read count of the first request.

// File: rtl/dctx_pkg.sv
package dctx_pkg;
  localparam int WORD_W     = 32;
  localparam int PAGE_SH    = 12;
  localparam int PTE_WR_BIT = 1;
  localparam int EFF_W      = WORD_W + 1;

  typedef enum logic [1:0] {
    ACC_RW  = 2'd0,
    ACC_RO  = 2'd1,
    ACC_WO  = 2'd2,
    ACC_RW2 = 2'd3
  } acc_e;

  typedef struct packed {
    logic [11:0] adjust;
    logic [1:0]  rsvd;
    logic [1:0]  tgt;
    logic [1:0]  acc;
    logic        linear;
    logic        pt_present;
    logic [11:0] cls;
  } ctl_word_t;

  typedef enum logic [2:0] {
    S_IDLE, S_CTL_RD, S_CTL_WT, S_LIM_RD, S_LIM_WT, S_PTE_RD, S_PTE_WT
  } state_e;
endpackage

// File: rtl/dctx_perm_check.sv
module dctx_perm_check
  import dctx_pkg::*;
(
  input  logic [WORD_W-1:0] offset,
  input  logic [WORD_W-1:0] limit,
  input  logic              write,
  input  logic [1:0]        acc,
  output logic              deny
);
  logic over_limit;
  logic dir_bad;

  always_comb begin
    over_limit = offset > limit;
    dir_bad    = (write && acc == ACC_RO) || (!write && acc == ACC_WO);
    deny       = over_limit || dir_bad;
  end
endmodule

// File: rtl/dctx_addr_gen.sv
module dctx_addr_gen
  import dctx_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0]     base,
  input  logic [WORD_W-1:0] offset,
  input  logic [11:0]       adjust,
  input  logic              linear,
  input  logic [WORD_W-1:0] pte,
  output logic [AW-1:0]     pte_addr,
  output logic [WORD_W-1:0] phys
);
  localparam int IDX_W = EFF_W - PAGE_SH;

  logic [EFF_W-1:0]  eff;
  logic [IDX_W-1:0]  page_idx;
  logic [AW-1:0]     idx_trunc;
  logic [WORD_W-1:0] frame;

  always_comb begin
    eff       = {1'b0, offset} + {{(EFF_W-12){1'b0}}, adjust};
    page_idx  = eff[EFF_W-1:PAGE_SH];
    idx_trunc = AW'(page_idx);
    pte_addr  = base + AW'(2) + (linear ? '0 : idx_trunc);
    frame     = {pte[WORD_W-1:PAGE_SH], {PAGE_SH{1'b0}}};
    if (linear) phys = frame + eff[WORD_W-1:0];
    else        phys = {pte[WORD_W-1:PAGE_SH], eff[PAGE_SH-1:0]};
  end
endmodule

// File: rtl/dctx_xlate.sv
module dctx_xlate
  import dctx_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_base,
  input  logic [WORD_W-1:0] req_offset,
  output logic              busy,
  output logic              rd_en,
  output logic [AW-1:0]     rd_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic              done,
  output logic              fault,
  output logic [WORD_W-1:0] phys_addr,
  output logic [1:0]        target
);
  state_e            state;
  logic [AW-1:0]     base_q;
  logic [WORD_W-1:0] off_q;
  logic              wr_q;
  logic [11:0]       adj_q;
  logic [1:0]        tgt_q;
  logic [1:0]        acc_q;
  logic              lin_q;
  ctl_word_t         ctl_in;
  logic              deny;
  logic [AW-1:0]     pte_addr;
  logic [WORD_W-1:0] phys_c;

  assign ctl_in = ctl_word_t'(rd_data);
  assign busy   = (state != S_IDLE);

  dctx_perm_check perm_i (
    .offset (off_q),
    .limit  (rd_data),
    .write  (wr_q),
    .acc    (acc_q),
    .deny   (deny)
  );

  dctx_addr_gen #(.AW(AW)) agen_i (
    .base     (base_q),
    .offset   (off_q),
    .adjust   (adj_q),
    .linear   (lin_q),
    .pte      (rd_data),
    .pte_addr (pte_addr),
    .phys     (phys_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      base_q    <= '0;
      off_q     <= '0;
      wr_q      <= 1'b0;
      adj_q     <= '0;
      tgt_q     <= '0;
      acc_q     <= '0;
      lin_q     <= 1'b0;
      rd_en     <= 1'b0;
      rd_addr   <= '0;
      done      <= 1'b0;
      fault     <= 1'b0;
      phys_addr <= '0;
      target    <= '0;
    end else begin
      done  <= 1'b0;
      rd_en <= 1'b0;
      unique case (state)
        S_IDLE: if (req_valid) begin
          base_q  <= req_base;
          off_q   <= req_offset;
          wr_q    <= req_write;
          rd_en   <= 1'b1;
          rd_addr <= req_base;
          state   <= S_CTL_RD;
        end
        S_CTL_RD: state <= S_CTL_WT;
        S_CTL_WT: begin
          adj_q   <= ctl_in.adjust;
          tgt_q   <= ctl_in.tgt;
          acc_q   <= ctl_in.acc;
          lin_q   <= ctl_in.linear;
          rd_en   <= 1'b1;
          rd_addr <= base_q + AW'(1);
          state   <= S_LIM_RD;
        end
        S_LIM_RD: state <= S_LIM_WT;
        S_LIM_WT: begin
          if (deny) begin
            done      <= 1'b1;
            fault     <= 1'b1;
            phys_addr <= '0;
            target    <= '0;
            state     <= S_IDLE;
          end else begin
            rd_en   <= 1'b1;
            rd_addr <= pte_addr;
            state   <= S_PTE_RD;
          end
        end
        S_PTE_RD: state <= S_PTE_WT;
        S_PTE_WT: begin
          done  <= 1'b1;
          state <= S_IDLE;
          if (wr_q && !rd_data[PTE_WR_BIT]) begin
            fault     <= 1'b1;
            phys_addr <= '0;
            target    <= '0;
          end else begin
            fault     <= 1'b0;
            phys_addr <= phys_c;
            target    <= tgt_q;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dctx_xlate_chk.sv
module dctx_xlate_chk #(
  parameter int AW = 16
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        busy,
  input logic        rd_en,
  input logic        done,
  input logic        fault,
  input logic [31:0] phys_addr,
  input logic [1:0]  target
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R10
  start_req_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));

  // R9
  fault_noaddr_chk: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> (phys_addr == 32'd0 && target == 2'd0));

  // R11
  read_single_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !rd_en);

  // R11
  read_busy_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> busy);
endmodule

bind dctx_xlate dctx_xlate_chk #(.AW(AW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .busy      (busy),
  .rd_en     (rd_en),
  .done      (done),
  .fault     (fault),
  .phys_addr (phys_addr),
  .target    (target)
);

// File: tb/dctx_xlate_tb_top.sv
module dctx_xlate_tb_top;
  localparam int AW = 8;

  typedef struct {
    logic        flt;
    logic [31:0] pa;
    logic [1:0]  tg;
    int          nrd;
    string       tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_base = '0;
  logic [31:0]   req_offset = '0;
  logic          busy, rd_en, done, fault;
  logic [AW-1:0] rd_addr;
  logic [31:0]   rd_data, phys_addr;
  logic [1:0]    target;

  logic [31:0] mem [256];
  int checks = 0;
  int failures = 0;
  int rd_count = 0;
  bit finished = 0;
  exp_t sb[$];

  always #5 clk = ~clk;

  always_ff @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  dctx_xlate #(.AW(AW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_base(req_base), .req_offset(req_offset), .busy(busy), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .done(done), .fault(fault),
    .phys_addr(phys_addr), .target(target)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [AW-1:0] b, input logic [31:0] off, input logic wr, input string tag);
    exp_t e;
    logic [31:0] ctl, lim, pte;
    logic [32:0] eff;
    logic [AW-1:0] idx;
    ctl = mem[b]; lim = mem[b + AW'(1)];
    e.tag = tag; e.pa = 0; e.tg = 0; e.flt = 0;
    if (off > lim || (wr && ctl[15:14] == 2'd1) || (!wr && ctl[15:14] == 2'd2)) begin
      e.flt = 1; e.nrd = 2; return e;
    end
    eff = {1'b0, off} + {21'd0, ctl[31:20]};
    idx = ctl[13] ? '0 : AW'(eff >> 12);
    pte = mem[b + AW'(2) + idx];
    e.nrd = 3;
    if (wr && !pte[1]) begin e.flt = 1; return e; end
    e.pa = ctl[13] ? ({pte[31:12], 12'h000} + eff[31:0]) : {pte[31:12], eff[11:0]};
    e.tg = ctl[17:16];
    return e;
  endfunction

  task automatic drive(input logic [AW-1:0] b, input logic [31:0] off, input logic wr, input string tag, input bit poke = 0);
    sb.push_back(model(b, off, wr, tag));
    @(negedge clk);
    req_valid = 1; req_base = b; req_offset = off; req_write = wr;
    @(negedge clk);
    if (poke) begin
      // R10: a request while busy must be ignored
      req_base = b + AW'(8); req_offset = 32'hFFFF_FFFF; req_write = ~wr;
      @(negedge clk);
    end
    req_valid = 0;
    while (busy) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (rd_en) rd_count++;
      if (done) begin
        if (sb.size() == 0) begin
          check(0, "R10 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(fault == e.flt, {e.tag, " fault"}, fault, e.flt);
          check(phys_addr == e.pa, {e.tag, " phys_addr"}, phys_addr, e.pa);
          check(target == e.tg, {e.tag, " target"}, target, e.tg);
          check(rd_count == e.nrd, {"R11 ", e.tag, " reads"}, rd_count, e.nrd);
        end
        rd_count = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    // linear, RW, target 2, adjust 0x345, limit 0x2FFF
    mem[8'h10] = {12'h345, 2'b00, 2'd2, 2'd0, 1'b1, 1'b1, 12'h03D};
    mem[8'h11] = 32'h0000_2FFF;
    mem[8'h12] = 32'h00AB_C002;
    // paged, RW, target 3, adjust 0x800, limit 0x3FFF
    mem[8'h40] = {12'h800, 2'b00, 2'd3, 2'd0, 1'b0, 1'b1, 12'h03D};
    mem[8'h41] = 32'h0000_3FFF;
    mem[8'h42] = 32'h1000_0002;
    mem[8'h43] = 32'h2220_0000;
    mem[8'h44] = 32'h3330_0002;
    mem[8'h45] = 32'h4440_0002;
    mem[8'h46] = 32'h5550_0002;
    // linear read-only, target 1
    mem[8'h80] = {12'h010, 2'b00, 2'd1, 2'd1, 1'b1, 1'b1, 12'h03D};
    mem[8'h81] = 32'h0000_0FFF;
    mem[8'h82] = 32'h0070_0002;
    // linear write-only, target 0
    mem[8'hA0] = {12'h000, 2'b00, 2'd0, 2'd2, 1'b1, 1'b1, 12'h03D};
    mem[8'hA1] = 32'h0000_00FF;
    mem[8'hA2] = 32'h0090_0002;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    check(!done && !fault && !busy && !rd_en, "R1 reset flags", {done, fault, busy, rd_en}, 0);
    check(phys_addr == 0 && target == 0, "R1 reset outputs", phys_addr, 0);
    rst = 0;

    drive(8'h10, 32'h0, 0, "R4 linear read");
    drive(8'h10, 32'h1000, 1, "R4 R2 linear write");
    drive(8'h10, 32'h2FFF, 0, "R3 at limit");
    drive(8'h10, 32'h3000, 0, "R3 R9 over limit");
    drive(8'h40, 32'h0100, 0, "R5 page0");
    drive(8'h40, 32'h0900, 0, "R5 carry into page1");
    drive(8'h40, 32'h0900, 1, "R8 write page no-wr");
    drive(8'h40, 32'h2A00, 1, "R5 page3 write");
    drive(8'h40, 32'h37FF, 0, "R5 last page");
    drive(8'h80, 32'h0020, 1, "R6 write ro");
    drive(8'h80, 32'h0020, 0, "R6 read ro");
    drive(8'hA0, 32'h0004, 0, "R7 read wo");
    drive(8'hA0, 32'h0004, 1, "R7 write wo");
    drive(8'h10, 32'h0123, 0, "R10 busy ignore", 1);
    repeat (10) @(negedge clk);
    check(sb.size() == 0, "R10 pending results", sb.size(), 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule